// File: doc/BRIEF.md
# Expansion Card CSR Decoder

This block sits on the slave side of a host local bus inside an add-on I/O card. It watches two select inputs: one opens a 1 MB region reached one byte at a time, the other opens a 1 MB region reached sixteen bits at a time. Every access starts with an address strobe and finishes with a one-cycle ready on the next clock. The identification area near the bottom of the space is read-only and filled from parameters. It holds a fixed flag, the negated flag, two revision bytes, a serial number and three base/length descriptor pairs.

A small register window at offset 0x40000 holds the control state. It has the interrupt source identifiers for both directions, an operational status byte, a run-control byte, the card type read from an 8-way DIP switch, and a write-only strobe that re-arms the card-to-host interrupt. No vector cycle exists. Whichever side is interrupted reads an ID register to learn the cause. After the card-to-host line fires, it stays asserted and masked until the host writes the re-arm strobe. Any location that is not implemented reads as all ones.

Top module: `xcard_csr_dec`

## Requirements
- R1: `ready` is high for exactly the one clock after a cycle where `addr_strobe` is high together with `sel_byte` or `sel_word`. It is low after any other cycle, including a strobe with neither select.
- R2: Identification bytes are little-endian. Offset 0x0/0x1 holds the flag (default 0xA55A). 0x2/0x3 holds its two's complement. 0x4 holds the hardware revision and 0x5 the firmware revision. 0x6/0x7 holds the serial number. Six 32-bit words follow at 0x08, 0x0C, 0x10, 0x14, 0x18 and 0x1C, in this order: CSR base, CSR length, RAM base, RAM length, NVRAM base, NVRAM length.
- R3: A read of an unimplemented location returns 0xFF in that byte lane. Unimplemented locations include 0x20–0x3FFFF, odd CSR offsets, offsets 0x4000C and above, and the write-only registers at 0x40002 and 0x4000A.
- R4: A byte-region read returns the addressed byte in `rdata[7:0]` and 0xFF in `rdata[15:8]`. A word-region read ignores address bit 0 and returns the even byte in `rdata[7:0]` and the odd byte in `rdata[15:8]`.
- R5: The run-control register at 0x40006 resets to 0x00, holds the last byte written to it, and drives `run_ctrl`.
- R6: In the word region, `lane_en[0]` gates writes of `wdata[7:0]` to the even byte and `lane_en[1]` gates writes of `wdata[15:8]` to the odd byte. In the byte region, `wdata[7:0]` is written whatever `lane_en` holds.
- R7: 0x40008 reads the `dip_sw` input and 0x40004 reads the `card_status` input, both as sampled at the strobe.
- R8: A `card_evt` pulse while the interrupt is armed stores `card_src` in the ID register at 0x40000 and drives `irq_to_host_n` low from the next clock. It also disarms the interrupt. Events that arrive while it is disarmed change neither the line nor the stored ID.
- R9: Any write to 0x4000A re-arms the interrupt and releases `irq_to_host_n` from the next clock. When a re-arm and an event fall in the same cycle, the re-arm wins.
- R10: A write to 0x40002 sets `host_flag` and loads `host_id` from the written byte. `card_ack` clears `host_flag`, and a write in the same cycle wins over the acknowledge.
- R11: Writes to the identification area and to read-only CSR offsets leave every register unchanged.
- R12: After reset: `ready` is 0, `rdata` is 0xFFFF, `irq_to_host_n` is 1, `host_flag` is 0 and `run_ctrl` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_byte | input | 1 | Select for the byte-access region |
| sel_word | input | 1 | Select for the 16-bit access region |
| addr_strobe | input | 1 | Marks the first cycle of an access |
| addr | input | 20 | Byte offset inside the selected region |
| wr_en | input | 1 | 1 for a write, 0 for a read |
| lane_en | input | 2 | Byte-lane enables for word-region writes |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid while `ready` is high |
| ready | output | 1 | One-cycle access completion |
| dip_sw | input | 8 | Card-type DIP switch |
| card_status | input | 8 | Operational status from the card |
| card_evt | input | 1 | Card-side interrupt request pulse |
| card_src | input | 8 | Source ID that goes with `card_evt` |
| card_ack | input | 1 | Card side acknowledges the host interrupt |
| irq_to_host_n | output | 1 | Active-low interrupt to the host |
| host_flag | output | 1 | Host-to-card interrupt pending |
| host_id | output | 8 | Host-to-card interrupt ID |
| run_ctrl | output | 8 | Programming and run control byte |

## Verification
The properties assume that `sel_byte` and `sel_word` are never high together in a strobe cycle. They also assume that the byte region only sees byte accesses and the word region only sees word accesses. The stimulus keeps to both rules: every access task raises exactly one select for a single strobe cycle, then returns the bus to idle before the next access. The interrupt properties also assume that `card_evt` and the re-arm write do not share a cycle unless the re-arm priority is being exercised. The bench never lines them up, so that case is covered only by the property.

// File: rtl/xcard_pkg.sv
package xcard_pkg;

  // Offset of the CSR window inside the byte region
  localparam int unsigned CSR_WIN_OFF = 32'h0004_0000;
  // Bytes covered by the identification table that carry data
  localparam int unsigned ID_USED_BYTES = 32;

  typedef enum logic [2:0] {
    SLOT_NONE,
    SLOT_SRC_ID,
    SLOT_HOST_ID,
    SLOT_STATUS,
    SLOT_RUN,
    SLOT_CARD_ID,
    SLOT_REARM
  } csr_slot_e;

  // Map the low nibble of a CSR-window offset to a register slot
  function automatic csr_slot_e slot_of(input logic [3:0] low);
    case (low)
      4'h0:    return SLOT_SRC_ID;
      4'h2:    return SLOT_HOST_ID;
      4'h4:    return SLOT_STATUS;
      4'h6:    return SLOT_RUN;
      4'h8:    return SLOT_CARD_ID;
      4'hA:    return SLOT_REARM;
      default: return SLOT_NONE;
    endcase
  endfunction

  // Little-endian byte pick out of a 32-bit word
  function automatic logic [7:0] le_pick(input logic [31:0] w, input logic [1:0] idx);
    return 8'(w >> (8 * idx));
  endfunction

  // Two's complement of a 16-bit flag
  function automatic logic [15:0] negate16(input logic [15:0] v);
    return (~v) + 16'd1;
  endfunction

endpackage

// File: rtl/xcard_id_rom.sv
module xcard_id_rom
  import xcard_pkg::*;
#(
  parameter int unsigned ADDR_W   = 20,
  parameter logic [15:0] FLAG     = 16'hA55A,
  parameter logic [7:0]  HW_REV   = 8'h03,
  parameter logic [7:0]  FW_REV   = 8'h11,
  parameter logic [15:0] SERIAL   = 16'h0123,
  parameter logic [31:0] CSR_BASE = 32'h0004_0000,
  parameter logic [31:0] CSR_LEN  = 32'h0000_000C,
  parameter logic [31:0] RAM_BASE = 32'h0008_0000,
  parameter logic [31:0] RAM_LEN  = 32'h0001_0000,
  parameter logic [31:0] NV_BASE  = 32'h000C_0000,
  parameter logic [31:0] NV_LEN   = 32'h0000_2000
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [7:0]        byte_o,
  output logic              hit_o
);
  localparam int unsigned WORDS  = ID_USED_BYTES / 4;
  localparam int unsigned WIDX_W = $clog2(WORDS);
  localparam int unsigned HI_LSB = $clog2(ID_USED_BYTES);

  logic [31:0] table_w [WORDS];

  always_comb begin
    table_w[0] = {negate16(FLAG), FLAG};
    table_w[1] = {SERIAL, FW_REV, HW_REV};
    table_w[2] = CSR_BASE;
    table_w[3] = CSR_LEN;
    table_w[4] = RAM_BASE;
    table_w[5] = RAM_LEN;
    table_w[6] = NV_BASE;
    table_w[7] = NV_LEN;
  end

  assign hit_o  = (addr_i[ADDR_W-1:HI_LSB] == '0);
  assign byte_o = le_pick(table_w[addr_i[HI_LSB-1:2]], addr_i[1:0]);

  logic [WIDX_W-1:0] unused_chk;
  assign unused_chk = addr_i[HI_LSB-1:2];
endmodule

// File: rtl/xcard_csr_regs.sv
module xcard_csr_regs
  import xcard_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned LANES  = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [LANES-1:0][ADDR_W-1:0]  lane_addr_i,
  input  logic [LANES-1:0]              lane_wr_i,
  input  logic [LANES-1:0][7:0]         lane_wdata_i,
  input  logic [7:0]                    src_id_i,
  input  logic [7:0]                    status_i,
  input  logic [7:0]                    dip_i,
  output logic [LANES-1:0][7:0]         lane_rbyte_o,
  output logic [LANES-1:0]              lane_hit_o,
  output logic [7:0]                    run_o,
  output logic                          rearm_o,
  output logic                          host_wr_o,
  output logic [7:0]                    host_data_o
);
  localparam logic [ADDR_W-1:0] WIN = ADDR_W'(CSR_WIN_OFF);

  csr_slot_e       slot [LANES];
  logic [LANES-1:0] in_win;
  logic            run_wr;
  logic [7:0]      run_data;
  logic [7:0]      run_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign in_win[g] = (lane_addr_i[g][ADDR_W-1:4] == WIN[ADDR_W-1:4]);
    assign slot[g]   = in_win[g] ? slot_of(lane_addr_i[g][3:0]) : SLOT_NONE;

    always_comb begin
      lane_hit_o[g]   = 1'b1;
      case (slot[g])
        SLOT_SRC_ID:  lane_rbyte_o[g] = src_id_i;
        SLOT_STATUS:  lane_rbyte_o[g] = status_i;
        SLOT_RUN:     lane_rbyte_o[g] = run_q;
        SLOT_CARD_ID: lane_rbyte_o[g] = dip_i;
        default: begin
          lane_rbyte_o[g] = 8'hFF;
          lane_hit_o[g]   = 1'b0;
        end
      endcase
    end
  end

  always_comb begin
    run_wr      = 1'b0;
    run_data    = 8'h00;
    rearm_o     = 1'b0;
    host_wr_o   = 1'b0;
    host_data_o = 8'h00;
    for (int k = 0; k < LANES; k++) begin
      if (lane_wr_i[k]) begin
        case (slot[k])
          SLOT_RUN: begin
            run_wr   = 1'b1;
            run_data = lane_wdata_i[k];
          end
          SLOT_HOST_ID: begin
            host_wr_o   = 1'b1;
            host_data_o = lane_wdata_i[k];
          end
          SLOT_REARM: rearm_o = 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      run_q <= 8'h00;
    else if (run_wr) run_q <= run_data;
  end

  assign run_o = run_q;
endmodule

// File: rtl/xcard_irq_ctl.sv
module xcard_irq_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       card_evt_i,
  input  logic [7:0] card_src_i,
  input  logic       rearm_i,
  input  logic       host_wr_i,
  input  logic [7:0] host_data_i,
  input  logic       card_ack_i,
  output logic       irq_n_o,
  output logic [7:0] src_id_o,
  output logic       host_flag_o,
  output logic [7:0] host_id_o
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q     <= 1'b1;
      src_id_o    <= 8'h00;
      host_flag_o <= 1'b0;
      host_id_o   <= 8'h00;
    end else begin
      if (rearm_i) begin
        armed_q <= 1'b1;
      end else if (card_evt_i && armed_q) begin
        armed_q  <= 1'b0;
        src_id_o <= card_src_i;
      end
      if (host_wr_i) begin
        host_flag_o <= 1'b1;
        host_id_o   <= host_data_i;
      end else if (card_ack_i) begin
        host_flag_o <= 1'b0;
      end
    end
  end

  assign irq_n_o = armed_q;
endmodule

// File: rtl/xcard_csr_dec.sv
module xcard_csr_dec
  import xcard_pkg::*;
#(
  parameter int unsigned ADDR_W   = 20,
  parameter logic [15:0] FLAG     = 16'hA55A,
  parameter logic [7:0]  HW_REV   = 8'h03,
  parameter logic [7:0]  FW_REV   = 8'h11,
  parameter logic [15:0] SERIAL   = 16'h0123,
  parameter logic [31:0] CSR_BASE = 32'h0004_0000,
  parameter logic [31:0] CSR_LEN  = 32'h0000_000C,
  parameter logic [31:0] RAM_BASE = 32'h0008_0000,
  parameter logic [31:0] RAM_LEN  = 32'h0001_0000,
  parameter logic [31:0] NV_BASE  = 32'h000C_0000,
  parameter logic [31:0] NV_LEN   = 32'h0000_2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_byte,
  input  logic              sel_word,
  input  logic              addr_strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [1:0]        lane_en,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  output logic              ready,
  input  logic [7:0]        dip_sw,
  input  logic [7:0]        card_status,
  input  logic              card_evt,
  input  logic [7:0]        card_src,
  input  logic              card_ack,
  output logic              irq_to_host_n,
  output logic              host_flag,
  output logic [7:0]        host_id,
  output logic [7:0]        run_ctrl
);
  localparam int unsigned LANES = 2;

  // Named internal events, also observed by the checker
  logic       acc_go;
  logic       is_word;
  logic       rearm_w;
  logic       host_id_wr;
  logic [7:0] host_wdata;
  logic [7:0] src_id_q;

  logic [LANES-1:0][ADDR_W-1:0] lane_addr;
  logic [LANES-1:0]             lane_wr;
  logic [LANES-1:0][7:0]        lane_wdata;
  logic [LANES-1:0][7:0]        id_byte;
  logic [LANES-1:0]             id_hit;
  logic [LANES-1:0][7:0]        csr_byte;
  logic [LANES-1:0]             csr_hit;
  logic [LANES-1:0][7:0]        rd_byte;
  logic [15:0]                  rd_next;

  assign acc_go  = addr_strobe && (sel_byte || sel_word);
  assign is_word = sel_word && !sel_byte;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_even
      assign lane_addr[g] = is_word ? {addr[ADDR_W-1:1], 1'b0} : addr;
      assign lane_wr[g]   = acc_go && wr_en && (!is_word || lane_en[g]);
    end else begin : g_odd
      assign lane_addr[g] = {addr[ADDR_W-1:1], 1'b1};
      assign lane_wr[g]   = acc_go && wr_en && is_word && lane_en[g];
    end
    assign lane_wdata[g] = wdata[8*g +: 8];

    xcard_id_rom #(
      .ADDR_W(ADDR_W), .FLAG(FLAG), .HW_REV(HW_REV), .FW_REV(FW_REV),
      .SERIAL(SERIAL), .CSR_BASE(CSR_BASE), .CSR_LEN(CSR_LEN),
      .RAM_BASE(RAM_BASE), .RAM_LEN(RAM_LEN), .NV_BASE(NV_BASE), .NV_LEN(NV_LEN)
    ) id_rom_i (
      .addr_i (lane_addr[g]),
      .byte_o (id_byte[g]),
      .hit_o  (id_hit[g])
    );

    assign rd_byte[g] = id_hit[g]  ? id_byte[g]  :
                        csr_hit[g] ? csr_byte[g] : 8'hFF;
  end

  xcard_csr_regs #(.ADDR_W(ADDR_W), .LANES(LANES)) csr_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .lane_addr_i  (lane_addr),
    .lane_wr_i    (lane_wr),
    .lane_wdata_i (lane_wdata),
    .src_id_i     (src_id_q),
    .status_i     (card_status),
    .dip_i        (dip_sw),
    .lane_rbyte_o (csr_byte),
    .lane_hit_o   (csr_hit),
    .run_o        (run_ctrl),
    .rearm_o      (rearm_w),
    .host_wr_o    (host_id_wr),
    .host_data_o  (host_wdata)
  );

  xcard_irq_ctl irq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .card_evt_i  (card_evt),
    .card_src_i  (card_src),
    .rearm_i     (rearm_w),
    .host_wr_i   (host_id_wr),
    .host_data_i (host_wdata),
    .card_ack_i  (card_ack),
    .irq_n_o     (irq_to_host_n),
    .src_id_o    (src_id_q),
    .host_flag_o (host_flag),
    .host_id_o   (host_id)
  );

  assign rd_next = is_word ? {rd_byte[1], rd_byte[0]} : {8'hFF, rd_byte[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready <= 1'b0;
      rdata <= 16'hFFFF;
    end else begin
      ready <= acc_go;
      if (acc_go && !wr_en) rdata <= rd_next;
    end
  end
endmodule

// File: rtl/xcard_csr_dec_chk.sv
module xcard_csr_dec_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_go,
  input logic        sel_byte,
  input logic        wr_en,
  input logic        ready,
  input logic [15:0] rdata,
  input logic        card_evt,
  input logic [7:0]  card_src,
  input logic        rearm_w,
  input logic        host_id_wr,
  input logic        card_ack,
  input logic        irq_to_host_n,
  input logic [7:0]  src_id_q,
  input logic        host_flag
);
  p_ready_after_go_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_go |=> ready);

  p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_go |=> !ready);

  p_byte_upper_ff_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_go && sel_byte && !wr_en) |=> (rdata[15:8] == 8'hFF));

  p_irq_fire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (card_evt && irq_to_host_n && !rearm_w) |=> (!irq_to_host_n && src_id_q == $past(card_src)));

  p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_to_host_n && !rearm_w) |=> (!irq_to_host_n && $stable(src_id_q)));

  p_rearm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_w |=> irq_to_host_n);

  p_host_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    host_id_wr |=> host_flag);

  p_host_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (card_ack && !host_id_wr) |=> !host_flag);
endmodule

bind xcard_csr_dec xcard_csr_dec_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .acc_go        (acc_go),
  .sel_byte      (sel_byte),
  .wr_en         (wr_en),
  .ready         (ready),
  .rdata         (rdata),
  .card_evt      (card_evt),
  .card_src      (card_src),
  .rearm_w       (rearm_w),
  .host_id_wr    (host_id_wr),
  .card_ack      (card_ack),
  .irq_to_host_n (irq_to_host_n),
  .src_id_q      (src_id_q),
  .host_flag     (host_flag)
);

// File: tb/xcard_csr_dec_tb.sv
module xcard_csr_dec_tb_top;
  localparam int CLK_PERIOD = 10;

  localparam logic [15:0] T_FLAG   = 16'hA55A;
  localparam logic [7:0]  T_HW     = 8'h03;
  localparam logic [7:0]  T_FW     = 8'h11;
  localparam logic [15:0] T_SERIAL = 16'h0123;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_byte = 1'b0, sel_word = 1'b0, addr_strobe = 1'b0, wr_en = 1'b0;
  logic [19:0] addr = '0;
  logic [1:0]  lane_en = 2'b00;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        ready;
  logic [7:0]  dip_sw = 8'h00, card_status = 8'h00, card_src = 8'h00;
  logic        card_evt = 1'b0, card_ack = 1'b0;
  logic        irq_to_host_n, host_flag;
  logic [7:0]  host_id, run_ctrl;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Bench-side model state
  logic [7:0] m_run = 8'h00;
  logic [7:0] m_src = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  xcard_csr_dec dut_i (
    .clk(clk), .rst_n(rst_n), .sel_byte(sel_byte), .sel_word(sel_word),
    .addr_strobe(addr_strobe), .addr(addr), .wr_en(wr_en), .lane_en(lane_en),
    .wdata(wdata), .rdata(rdata), .ready(ready), .dip_sw(dip_sw),
    .card_status(card_status), .card_evt(card_evt), .card_src(card_src),
    .card_ack(card_ack), .irq_to_host_n(irq_to_host_n), .host_flag(host_flag),
    .host_id(host_id), .run_ctrl(run_ctrl)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] desc_word(input int n);
    case (n)
      0: return 32'h0004_0000;
      1: return 32'h0000_000C;
      2: return 32'h0008_0000;
      3: return 32'h0001_0000;
      4: return 32'h000C_0000;
      default: return 32'h0000_2000;
    endcase
  endfunction

  // Expected byte at an offset, restated from the requirements
  function automatic logic [7:0] exp_byte(input int off);
    logic [15:0] neg;
    neg = 16'h0000 - T_FLAG;
    if (off == 0) return T_FLAG[7:0];
    if (off == 1) return T_FLAG[15:8];
    if (off == 2) return neg[7:0];
    if (off == 3) return neg[15:8];
    if (off == 4) return T_HW;
    if (off == 5) return T_FW;
    if (off == 6) return T_SERIAL[7:0];
    if (off == 7) return T_SERIAL[15:8];
    if (off >= 8 && off < 32) return 8'((desc_word((off - 8) / 4)) >> (8 * (off % 4)));
    if (off == 'h40000) return m_src;
    if (off == 'h40004) return card_status;
    if (off == 'h40006) return m_run;
    if (off == 'h40008) return dip_sw;
    return 8'hFF;
  endfunction

  task automatic acc(input bit word, input logic [19:0] a, input bit wr,
                     input logic [1:0] le, input logic [15:0] d, output logic [15:0] r);
    @(negedge clk);
    sel_byte = !word; sel_word = word; addr_strobe = 1'b1;
    addr = a; wr_en = wr; lane_en = le; wdata = d;
    @(negedge clk);
    chk("R1 ready after strobe", {31'd0, ready}, 32'd1);
    r = rdata;
    sel_byte = 1'b0; sel_word = 1'b0; addr_strobe = 1'b0; wr_en = 1'b0;
    @(negedge clk);
    chk("R1 ready drops", {31'd0, ready}, 32'd0);
  endtask

  task automatic rd_byte_chk(input string tag, input int off);
    logic [15:0] r;
    acc(1'b0, 20'(off), 1'b0, 2'b00, 16'h0, r);
    chk(tag, {16'd0, r}, {16'd0, 8'hFF, exp_byte(off)});
  endtask

  task automatic rd_word_chk(input string tag, input int off);
    logic [15:0] r;
    int ev;
    ev = off & ~1;
    acc(1'b1, 20'(off), 1'b0, 2'b00, 16'h0, r);
    chk(tag, {16'd0, r}, {16'd0, exp_byte(ev + 1), exp_byte(ev)});
  endtask

  task automatic card_event(input logic [7:0] s);
    @(negedge clk);
    card_evt = 1'b1; card_src = s;
    @(negedge clk);
    card_evt = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 ready", {31'd0, ready}, 32'd0);
    chk("R12 rdata", {16'd0, rdata}, 32'h0000_FFFF);
    chk("R12 irq line", {31'd0, irq_to_host_n}, 32'd1);
    chk("R12 host flag", {31'd0, host_flag}, 32'd0);
    chk("R12 run ctrl", {24'd0, run_ctrl}, 32'd0);

    // R2 / R4 byte and word sweeps over the identification table and beyond
    for (int o = 0; o < 40; o++) rd_byte_chk("R2 R4 byte read", o);
    for (int o = 0; o < 40; o++) rd_word_chk("R2 R4 word read", o);

    // R3 unimplemented space
    rd_byte_chk("R3 id gap", 'h3FFFF);
    rd_byte_chk("R3 id gap mid", 'h12345);
    rd_byte_chk("R3 past window", 'h4000C);
    rd_byte_chk("R3 high", 'hFFFFF);
    rd_byte_chk("R3 region top", 'h80000);
    rd_byte_chk("R3 write-only host id", 'h40002);
    rd_byte_chk("R3 write-only rearm", 'h4000A);
    for (int o = 'h40001; o < 'h40010; o += 2) rd_byte_chk("R3 odd csr", o);
    rd_word_chk("R3 word write-only", 'h4000A);
    rd_word_chk("R3 word high", 'hFFFFE);

    // R7 inputs reflected
    for (int v = 0; v < 256; v += 37) begin
      dip_sw = 8'(v); card_status = 8'(v ^ 8'h5A);
      rd_byte_chk("R7 card id", 'h40008);
      rd_byte_chk("R7 status", 'h40004);
      rd_word_chk("R7 status word", 'h40004);
    end

    // R5 run control
    acc(1'b0, 20'h40006, 1'b1, 2'b00, 16'hEE3C, r); m_run = 8'h3C;
    chk("R5 run out", {24'd0, run_ctrl}, 32'h3C);
    rd_byte_chk("R5 run byte", 'h40006);
    rd_word_chk("R5 run word", 'h40006);

    // R6 lane gating in word region
    acc(1'b1, 20'h40006, 1'b1, 2'b00, 16'h0077, r);
    chk("R6 no lanes", {24'd0, run_ctrl}, 32'h3C);
    acc(1'b1, 20'h40006, 1'b1, 2'b10, 16'h0077, r);
    chk("R6 upper lane only", {24'd0, run_ctrl}, 32'h3C);
    acc(1'b1, 20'h40007, 1'b1, 2'b01, 16'hAB55, r); m_run = 8'h55;
    chk("R6 lower lane", {24'd0, run_ctrl}, 32'h55);
    acc(1'b0, 20'h40006, 1'b1, 2'b00, 16'h00C1, r); m_run = 8'hC1;
    chk("R6 byte region ignores lanes", {24'd0, run_ctrl}, 32'hC1);

    // R11 writes to read-only places
    acc(1'b1, 20'h00000, 1'b1, 2'b11, 16'h1234, r);
    acc(1'b0, 20'h40008, 1'b1, 2'b00, 16'h0099, r);
    acc(1'b0, 20'h40000, 1'b1, 2'b00, 16'h0066, r);
    acc(1'b0, 20'h40004, 1'b1, 2'b00, 16'h0066, r);
    rd_word_chk("R11 flag intact", 'h0);
    rd_byte_chk("R11 src id intact", 'h40000);
    chk("R11 run intact", {24'd0, run_ctrl}, 32'hC1);
    chk("R11 irq intact", {31'd0, irq_to_host_n}, 32'd1);
    chk("R11 host flag intact", {31'd0, host_flag}, 32'd0);

    // R8 interrupt fire and mask
    card_event(8'h21); m_src = 8'h21;
    chk("R8 irq asserted", {31'd0, irq_to_host_n}, 32'd0);
    rd_byte_chk("R8 src id", 'h40000);
    card_event(8'h99);
    chk("R8 masked line", {31'd0, irq_to_host_n}, 32'd0);
    rd_byte_chk("R8 masked id", 'h40000);
    // R9 re-arm
    acc(1'b0, 20'h4000A, 1'b1, 2'b00, 16'h0000, r);
    chk("R9 released", {31'd0, irq_to_host_n}, 32'd1);
    card_event(8'h42); m_src = 8'h42;
    chk("R9 fires again", {31'd0, irq_to_host_n}, 32'd0);
    rd_word_chk("R8 new id word", 'h40000);
    acc(1'b1, 20'h4000A, 1'b1, 2'b01, 16'h0000, r);
    chk("R9 word rearm", {31'd0, irq_to_host_n}, 32'd1);

    // R10 host-to-card
    acc(1'b0, 20'h40002, 1'b1, 2'b00, 16'h005C, r);
    chk("R10 flag set", {31'd0, host_flag}, 32'd1);
    chk("R10 id", {24'd0, host_id}, 32'h5C);
    @(negedge clk); card_ack = 1'b1;
    @(negedge clk); card_ack = 1'b0;
    chk("R10 ack clears", {31'd0, host_flag}, 32'd0);
    chk("R10 id kept", {24'd0, host_id}, 32'h5C);

    // R1 strobe without select
    @(negedge clk); addr_strobe = 1'b1; addr = 20'h0;
    @(negedge clk); chk("R1 no select", {31'd0, ready}, 32'd0);
    addr_strobe = 1'b0;
    @(negedge clk); chk("R1 idle", {31'd0, ready}, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule